// File: doc/BRIEF.md
# Interrupt Cause Bank

This block collects hardware interrupt events into three 32-bit cause groups (transmit, receive and miscellaneous) and presents them to software through a word-addressed register bus. Every group has a cause register, a per-bit clear-mode register, a pair of mask set/clear strobes and a mask readback. Each cause bit latches its event whether or not it is masked. Software chooses, bit by bit, whether that bit is cleared by reading it or by writing a one to it.

A summary register holds one bit per group. A bit is set while that group has any unmasked pending cause. Reading the summary register empties it, so the handler has no acknowledge to write. A software gate register sits between the summary bits and the single level-sensitive interrupt line. It lets a handler silence the line while it works through the groups without touching the per-group masks.

The bus is a single-cycle strobe interface. A write takes effect at the clock edge where `bus_valid` and `bus_write` are high. A read is sampled at the edge where `bus_valid` is high and `bus_write` is low, and its data is presented on `bus_rdata` after that edge.

Top module: `irq_cause_bank`

## Requirements
- R1: After reset every cause bit is 0, every clear-mode bit is 0, every group mask bit is 1, the gate register holds all ones (3'b111) and `irq_o` is low.
- R2: An event bit high at a clock edge sets the matching cause bit, and it does so even while that bit is masked. Group g occupies `ev_in[g*32 +: 32]`, with transmit g=0, receive g=1 and misc g=2.
- R3: Writing to mask-set (offset 0x08) sets the mask bits where the write data is 1. Writing to mask-clear (offset 0x0C) clears the mask bits where the write data is 1. Data bits that are 0 leave the mask unchanged. Mask-value (offset 0x10) reads back the current mask.
- R4: A cause bit whose clear-mode bit (offset 0x04) is 0 is cleared by writing 1 to it at the cause register (offset 0x00). Writing 0 to it, or reading it, leaves it set.
- R5: A cause bit whose clear-mode bit is 1 is returned by a read of the cause register and cleared by that read. Writes to the cause register do not affect it.
- R6: If an event sets a cause bit at the same edge where a read or a write-one would clear it, the bit stays set. A clear-on-read access still returns the bit.
- R7: Bit g of the summary register (address 0x60) is set at the edge after group g has any unmasked set cause bit, and it stays latched. A summary read returns its value and clears it. A bit whose source is still pending is set again at the same edge.
- R8: The gate register at 0x64 (bits 2:0) holds back summary bits whose gate bit is 1. `irq_o` is high exactly while some summary bit is set with its gate bit at 0. Writing all ones keeps `irq_o` low.
- R9: When a mask-clear write unmasks a latched cause bit (gate open), `irq_o` stays low just after the write edge and is high after the following edge.
- R10: Group g's registers start at byte address g*0x20. Accesses whose address bits 1:0 are not 0, or that decode to no register, change no state and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe for one cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered after the read edge |
| ev_in | input | 96 | Event pulses, 32 per group |
| irq_o | output | 1 | Level interrupt request |

## Verification
The hardest state to reach from the ports is the collision of an event with a clear at the same edge. In clear-on-read mode this race also decides whether the returned data and the surviving bit agree. The bench drives the access and the event from the same task in the same cycle, for both clear modes. It then reads the cause register again to see what survived. The summary register is also awkward to probe, because its bit stays latched after the cause has gone and re-sets while the source persists. The bench removes the source first and then reads the summary twice, to separate the latch from the live OR.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;
   typedef enum logic [2:0] {
      REG_CAUSE = 3'd0,
      REG_MODE  = 3'd1,
      REG_MSET  = 3'd2,
      REG_MCLR  = 3'd3,
      REG_MVAL  = 3'd4
   } irq_reg_e;

   localparam logic [2:0] SUM_WORD  = 3'd0;
   localparam logic [2:0] GATE_WORD = 3'd1;
   localparam int GRP_SPAN_LOG2 = 5;
endpackage

// File: rtl/irq_cause_group.sv
module irq_cause_group #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] ev,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wr_cause,
   input  logic              wr_mode,
   input  logic              wr_mset,
   input  logic              wr_mclr,
   input  logic              rd_cause,
   output logic [DATA_W-1:0] cause_o,
   output logic [DATA_W-1:0] mode_o,
   output logic [DATA_W-1:0] mask_o,
   output logic              pend_o
);
   logic [DATA_W-1:0] cause_q, mode_q, mask_q;
   logic [DATA_W-1:0] cause_n, mask_n, w1c_hit, cor_hit;

   always_comb begin
      w1c_hit = wr_cause ? (wdata & ~mode_q) : '0;
      cor_hit = rd_cause ? (cause_q & mode_q) : '0;
      cause_n = (cause_q & ~w1c_hit & ~cor_hit) | ev;
      mask_n  = mask_q;
      if (wr_mset) mask_n = mask_n | wdata;
      if (wr_mclr) mask_n = mask_n & ~wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cause_q <= '0;
         mode_q  <= '0;
         mask_q  <= '1;
      end else begin
         cause_q <= cause_n;
         mask_q  <= mask_n;
         if (wr_mode) mode_q <= wdata;
      end
   end

   assign cause_o = cause_q;
   assign mode_o  = mode_q;
   assign mask_o  = mask_q;
   assign pend_o  = |(cause_q & ~mask_q);
endmodule

// File: rtl/irq_summary.sv
module irq_summary #(
   parameter int NUM_GRP = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_GRP-1:0] pend,
   input  logic               rd_sum,
   input  logic               wr_gate,
   input  logic [NUM_GRP-1:0] gate_wdata,
   output logic [NUM_GRP-1:0] sum_o,
   output logic [NUM_GRP-1:0] gate_o,
   output logic               irq_o
);
   logic [NUM_GRP-1:0] sum_q, gate_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_q  <= '0;
         gate_q <= '1;
      end else begin
         sum_q <= (rd_sum ? '0 : sum_q) | pend;
         if (wr_gate) gate_q <= gate_wdata;
      end
   end

   assign sum_o  = sum_q;
   assign gate_o = gate_q;
   assign irq_o  = |(sum_q & ~gate_q);
endmodule

// File: rtl/irq_cause_bank.sv
module irq_cause_bank
   import irq_cause_pkg::*;
#(
   parameter int NUM_GRP = 3,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bus_valid,
   input  logic                      bus_write,
   input  logic [ADDR_W-1:0]         bus_addr,
   input  logic [DATA_W-1:0]         bus_wdata,
   output logic [DATA_W-1:0]         bus_rdata,
   input  logic [NUM_GRP*DATA_W-1:0] ev_in,
   output logic                      irq_o
);
   localparam int GRP_W = ADDR_W - GRP_SPAN_LOG2;
   localparam logic [GRP_W-1:0] SUM_IDX = GRP_W'(NUM_GRP);

   if (DATA_W < NUM_GRP) begin : g_bad_width
      $error("DATA_W must hold one summary bit per group");
   end
   if ((1 << GRP_W) < NUM_GRP + 1) begin : g_bad_addr
      $error("ADDR_W too small for NUM_GRP groups plus summary block");
   end

   logic                 acc_ok;
   logic [GRP_W-1:0]     grp_sel;
   logic [2:0]           word_sel;
   irq_reg_e             reg_sel;

   assign acc_ok   = bus_valid && (bus_addr[1:0] == 2'b00);
   assign grp_sel  = bus_addr[ADDR_W-1:GRP_SPAN_LOG2];
   assign word_sel = bus_addr[4:2];
   assign reg_sel  = irq_reg_e'(word_sel);

   logic [DATA_W-1:0]         cause_a [NUM_GRP];
   logic [DATA_W-1:0]         mode_a  [NUM_GRP];
   logic [DATA_W-1:0]         mask_a  [NUM_GRP];
   logic [NUM_GRP-1:0]        pend_v;
   logic [NUM_GRP*DATA_W-1:0] cause_flat, mask_flat;

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      logic sel, wr, rd;
      assign sel = acc_ok && (grp_sel == GRP_W'(g));
      assign wr  = sel && bus_write;
      assign rd  = sel && !bus_write;

      irq_cause_group #(.DATA_W(DATA_W)) grp_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .ev       (ev_in[g*DATA_W +: DATA_W]),
         .wdata    (bus_wdata),
         .wr_cause (wr && reg_sel == REG_CAUSE),
         .wr_mode  (wr && reg_sel == REG_MODE),
         .wr_mset  (wr && reg_sel == REG_MSET),
         .wr_mclr  (wr && reg_sel == REG_MCLR),
         .rd_cause (rd && reg_sel == REG_CAUSE),
         .cause_o  (cause_a[g]),
         .mode_o   (mode_a[g]),
         .mask_o   (mask_a[g]),
         .pend_o   (pend_v[g])
      );
      assign cause_flat[g*DATA_W +: DATA_W] = cause_a[g];
      assign mask_flat[g*DATA_W +: DATA_W]  = mask_a[g];
   end

   logic               sum_blk;
   logic [NUM_GRP-1:0] sum_v, gate_v;

   assign sum_blk = acc_ok && (grp_sel == SUM_IDX);

   irq_summary #(.NUM_GRP(NUM_GRP)) sum_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .pend       (pend_v),
      .rd_sum     (sum_blk && !bus_write && word_sel == SUM_WORD),
      .wr_gate    (sum_blk && bus_write && word_sel == GATE_WORD),
      .gate_wdata (bus_wdata[NUM_GRP-1:0]),
      .sum_o      (sum_v),
      .gate_o     (gate_v),
      .irq_o      (irq_o)
   );

   logic [DATA_W-1:0] rd_mux;

   always_comb begin
      rd_mux = '0;
      for (int g = 0; g < NUM_GRP; g++) begin
         if (grp_sel == GRP_W'(g)) begin
            case (reg_sel)
               REG_CAUSE: rd_mux = cause_a[g];
               REG_MODE:  rd_mux = mode_a[g];
               REG_MVAL:  rd_mux = mask_a[g];
               default:   rd_mux = '0;
            endcase
         end
      end
      if (grp_sel == SUM_IDX) begin
         if (word_sel == SUM_WORD)  rd_mux = DATA_W'(sum_v);
         if (word_sel == GATE_WORD) rd_mux = DATA_W'(gate_v);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    bus_rdata <= '0;
      else if (bus_valid && !bus_write) bus_rdata <= acc_ok ? rd_mux : '0;
   end
endmodule

// File: rtl/irq_cause_bank_chk.sv
module irq_cause_bank_chk #(
   parameter int NUM_GRP = 3,
   parameter int DATA_W  = 32
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      bus_valid,
   input logic                      bus_write,
   input logic [NUM_GRP*DATA_W-1:0] ev_in,
   input logic [NUM_GRP*DATA_W-1:0] cause_flat,
   input logic [NUM_GRP*DATA_W-1:0] mask_flat,
   input logic [NUM_GRP-1:0]        pend_v,
   input logic [NUM_GRP-1:0]        gate_v,
   input logic                      irq_o
);
   AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_in != '0) |=> ((cause_flat & $past(ev_in)) == $past(ev_in))); // R6

   AST_CAUSE_CLEAR_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      ((~cause_flat & $past(cause_flat)) != '0) |-> $past(bus_valid)); // R4

   AST_MASK_CHANGE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_flat != $past(mask_flat)) |-> $past(bus_valid && bus_write)); // R3

   AST_GATE_CLOSED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (&gate_v) |-> !irq_o); // R8

   AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past((pend_v != '0) || (bus_valid && bus_write))); // R7
endmodule

bind irq_cause_bank irq_cause_bank_chk #(.NUM_GRP(NUM_GRP), .DATA_W(DATA_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_valid  (bus_valid),
   .bus_write  (bus_write),
   .ev_in      (ev_in),
   .cause_flat (cause_flat),
   .mask_flat  (mask_flat),
   .pend_v     (pend_v),
   .gate_v     (gate_v),
   .irq_o      (irq_o)
);

// File: tb/irq_cause_bank_tb.sv
module irq_cause_bank_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [95:0] ev_in = '0;
   logic        irq_o;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   irq_cause_bank dut_i (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ev_in(ev_in), .irq_o(irq_o)
   );

   localparam logic [7:0] TX = 8'h00, RX = 8'h20, MS = 8'h40;
   localparam logic [7:0] O_CAUSE = 8'h00, O_MODE = 8'h04, O_MSET = 8'h08,
                          O_MCLR = 8'h0C, O_MVAL = 8'h10;
   localparam logic [7:0] A_SUM = 8'h60, A_GATE = 8'h64;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc(input logic v, input logic w, input logic [7:0] a,
                      input logic [31:0] d, input logic [95:0] e,
                      output logic [31:0] r);
      @(negedge clk);
      bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d; ev_in = e;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0; ev_in = '0;
      r = bus_rdata;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      logic [31:0] r;
      cyc(1'b1, 1'b1, a, d, '0, r);
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] r);
      cyc(1'b1, 1'b0, a, '0, '0, r);
   endtask

   task automatic pulse(input logic [95:0] e);
      logic [31:0] r;
      cyc(1'b0, 1'b0, '0, '0, e, r);
   endtask

   task automatic t_reset;
      logic [31:0] r;
      rd(TX + O_MVAL, r); chk("R1 tx mask", r, 32'hFFFF_FFFF);
      rd(MS + O_MVAL, r); chk("R1 misc mask", r, 32'hFFFF_FFFF);
      rd(RX + O_MODE, r); chk("R1 rx mode", r, 32'h0);
      rd(RX + O_CAUSE, r); chk("R1 rx cause", r, 32'h0);
      rd(A_GATE, r); chk("R1 gate", r, 32'h7);
      chk("R1 irq", {31'b0, irq_o}, 32'h0);
   endtask

   task automatic t_latch_masked;
      logic [31:0] r;
      pulse({64'h0, 32'h5});
      rd(TX + O_CAUSE, r); chk("R2 masked latch", r, 32'h5);
      chk("R2 irq masked", {31'b0, irq_o}, 32'h0);
      rd(8'h61, r); chk("R10 misaligned read", r, 32'h0);
      cyc(1'b1, 1'b1, 8'h01, 32'hFFFF_FFFF, '0, r);
      rd(TX + O_CAUSE, r); chk("R10 misaligned write ignored", r, 32'h5);
   endtask

   task automatic t_mask_ops;
      logic [31:0] r;
      wr(RX + O_MCLR, 32'h0000_00F0);
      rd(RX + O_MVAL, r); chk("R3 mask clear", r, 32'hFFFF_FF0F);
      wr(RX + O_MSET, 32'h0000_0010);
      rd(RX + O_MVAL, r); chk("R3 mask set", r, 32'hFFFF_FF1F);
      wr(RX + O_MCLR, 32'h0);
      rd(RX + O_MVAL, r); chk("R3 zero write no effect", r, 32'hFFFF_FF1F);
   endtask

   task automatic t_w1c;
      logic [31:0] r;
      rd(TX + O_CAUSE, r); chk("R4 read keeps", r, 32'h5);
      wr(TX + O_CAUSE, 32'h4);
      rd(TX + O_CAUSE, r); chk("R4 w1c one bit", r, 32'h1);
      wr(TX + O_CAUSE, 32'h0);
      rd(TX + O_CAUSE, r); chk("R4 write zero keeps", r, 32'h1);
      wr(TX + O_CAUSE, 32'h1);
      rd(TX + O_CAUSE, r); chk("R4 cleared", r, 32'h0);
   endtask

   task automatic t_cor;
      logic [31:0] r;
      wr(RX + O_MODE, 32'hFFFF_FFFF);
      pulse({32'h0, 32'h30, 32'h0});
      rd(RX + O_CAUSE, r); chk("R5 cor returns", r, 32'h30);
      rd(RX + O_CAUSE, r); chk("R5 cor cleared", r, 32'h0);
      pulse({32'h0, 32'h30, 32'h0});
      wr(RX + O_CAUSE, 32'h30);
      rd(RX + O_CAUSE, r); chk("R5 write ignored", r, 32'h30);
      rd(RX + O_CAUSE, r); chk("R5 cleared after read", r, 32'h0);
   endtask

   task automatic t_race;
      logic [31:0] r;
      pulse({64'h0, 32'h2});
      cyc(1'b1, 1'b1, TX + O_CAUSE, 32'h2, {64'h0, 32'h2}, r);
      rd(TX + O_CAUSE, r); chk("R6 w1c race keeps", r, 32'h2);
      wr(TX + O_CAUSE, 32'h2);
      rd(TX + O_CAUSE, r); chk("R6 w1c then clear", r, 32'h0);
      pulse({32'h0, 32'h8, 32'h0});
      cyc(1'b1, 1'b0, RX + O_CAUSE, 32'h0, {32'h0, 32'h8, 32'h0}, r);
      chk("R6 cor race returns", r, 32'h8);
      rd(RX + O_CAUSE, r); chk("R6 cor race keeps", r, 32'h8);
      rd(RX + O_CAUSE, r); chk("R6 cor then clear", r, 32'h0);
   endtask

   task automatic t_sum_irq;
      logic [31:0] r;
      rd(A_SUM, r);
      rd(A_SUM, r); chk("R7 summary flushed", r, 32'h0);
      wr(MS + O_MCLR, 32'h1);
      pulse({32'h1, 64'h0});
      pulse('0);
      rd(A_SUM, r); chk("R7 misc summary bit", r, 32'h4);
      chk("R8 gate closed", {31'b0, irq_o}, 32'h0);
      wr(A_GATE, 32'h0);
      chk("R8 gate open", {31'b0, irq_o}, 32'h1);
      wr(A_GATE, 32'h7);
      chk("R8 all ones off", {31'b0, irq_o}, 32'h0);
      wr(A_GATE, 32'h0);
      wr(MS + O_CAUSE, 32'h1);
      pulse('0);
      chk("R7 summary latched", {31'b0, irq_o}, 32'h1);
      rd(A_SUM, r); chk("R7 read returns latched", r, 32'h4);
      chk("R7 read clears irq", {31'b0, irq_o}, 32'h0);
      rd(A_SUM, r); chk("R7 summary empty", r, 32'h0);
   endtask

   task automatic t_unmask;
      logic [31:0] r;
      pulse({64'h0, 32'h80});
      pulse('0); pulse('0);
      chk("R9 masked no irq", {31'b0, irq_o}, 32'h0);
      wr(TX + O_MCLR, 32'h80);
      chk("R9 not yet", {31'b0, irq_o}, 32'h0);
      @(negedge clk);
      chk("R9 raised", {31'b0, irq_o}, 32'h1);
      rd(A_SUM, r); chk("R7 pending re-sets", r, 32'h1);
      chk("R7 irq persists", {31'b0, irq_o}, 32'h1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_latch_masked;
      t_mask_ops;
      t_w1c;
      t_cor;
      t_race;
      t_sum_irq;
      t_unmask;
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule